// File: doc/BRIEF.md
# DMA Destination Stepping and Acknowledge Strobe Control

This block is the per-channel control slice of a four-channel DMA controller. For every channel it holds three programmable settings: how the destination address moves after a transfer, which bus cycle carries the acknowledge strobe, and that strobe's polarity. It also holds the channel's 32-bit destination address. Software writes these settings through a small write port and reads them back through a separate read port.

While a transfer runs, the controller names the active channel, the transfer size and the addressing style, and it pulses phase indications for the read cycle, the write cycle and transfer completion. The slice drives one acknowledge pin per channel during the proper cycle. On each completion it steps the active channel's destination address by the transfer size. If the programmed setting is illegal, it raises a one-cycle error pulse and leaves the address where it was. Only channels 0 and 1 let software program acknowledge timing and polarity. Channels 2 and 3 always behave as if both settings were zero.

Top module: `dma_dst_ack_ctrl`

## Requirements
- R1: After reset every control field and every destination address is 0, every acknowledge pin is high (inactive for active-low), and `cfg_err` is 0.
- R2: A write with `cfg_addr_sel`=0 loads the channel's control word. Bit 0 is the acknowledge timing (0 = read cycle, 1 = write cycle), bit 1 is the acknowledge polarity (0 = active-low, 1 = active-high) and bits 3:2 are the destination mode (00 fixed, 01 increment, 10 decrement, 11 prohibited). Readback with `rd_addr_sel`=0 returns these bits and zero above them, in the same cycle.
- R3: In increment mode, a completion adds 1, 2, 4 or 16 to the active channel's address for `xfer_size` 00 (byte), 01 (16-bit), 10 (32-bit) or 11 (16-byte block). The new value is visible the cycle after the completion edge.
- R4: In decrement mode, a completion subtracts 1, 2 or 4 for `xfer_size` 00, 01 or 10.
- R5: In fixed mode, a completion leaves the address unchanged and raises no error.
- R6: Two settings are illegal at a completion: mode 11 with any size, and mode 10 with size 11. In either case the address is held and `cfg_err` is 1 for exactly the one cycle after the completion edge.
- R7: A write with `cfg_addr_sel`=1 loads the channel's address directly. If that write meets a completion on the same channel in the same cycle, the write wins. Readback with `rd_addr_sel`=1 returns the address.
- R8: In dual address mode (`single_addr`=0), the active channel's acknowledge is asserted during `rd_cycle` when its timing bit is 0, and during `wr_cycle` when its timing bit is 1.
- R9: In single address mode, the active channel's acknowledge is asserted during either `rd_cycle` or `wr_cycle`, whatever its timing bit.
- R10: An asserted acknowledge equals the polarity bit. Otherwise the pin sits at the inverse of the polarity bit, including every channel that is not `xfer_ch`.
- R11: On channels 2 and 3, writes to control bits 1:0 are ignored, those bits read back 0, and the pins act as read-cycle timed and active-low.
- R12: Address stepping wraps modulo 2^32 in both directions.
- R13: A completion changes only the address of the channel named by `xfer_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel written |
| cfg_addr_sel | input | 1 | 0 writes the control word, 1 writes the destination address |
| cfg_wdata | input | 32 | Write data |
| rd_ch | input | 2 | Channel read back |
| rd_addr_sel | input | 1 | 0 reads the control word, 1 reads the address |
| rd_data | output | 32 | Readback data, combinational |
| xfer_ch | input | 2 | Active transfer channel |
| xfer_size | input | 2 | 00 byte, 01 16-bit, 10 32-bit, 11 16-byte block |
| single_addr | input | 1 | 1 single address mode, 0 dual address mode |
| rd_cycle | input | 1 | Data read cycle in progress |
| wr_cycle | input | 1 | Data write cycle in progress |
| xfer_done | input | 1 | Transfer completion, sampled on the clock edge |
| dst_addr | output | 32 | Destination address of `xfer_ch` |
| dack | output | 4 | Acknowledge pin level per channel |
| cfg_err | output | 1 | One-cycle illegal-setting pulse |

## Verification
The acknowledge pins, `dst_addr` and `rd_data` are combinational, so they are due in the same cycle as the phase inputs or the read selection. Address stepping, register loads and the error pulse appear one cycle after the edge that samples `xfer_done` or `cfg_we`. The error pulse falls again one cycle later. The driver changes inputs on the falling edge and queues each expected value only once the edges it depends on have passed. The monitor compares the queued values a quarter period after the next falling edge, so every comparison falls inside the cycle where its result is due.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;

  typedef enum logic [1:0] {
    DST_FIXED = 2'b00,
    DST_INC   = 2'b01,
    DST_DEC   = 2'b10,
    DST_BAD   = 2'b11
  } dst_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_BLK16 = 2'b11
  } xfer_size_e;

  localparam int CTRL_AM_BIT = 0;
  localparam int CTRL_AL_BIT = 1;
  localparam int CTRL_DM_LSB = 2;

  // Byte distance covered by one transfer of the given size.
  function automatic logic [4:0] step_bytes(xfer_size_e sz);
    case (sz)
      SZ_BYTE:  return 5'd1;
      SZ_HALF:  return 5'd2;
      SZ_WORD:  return 5'd4;
      default:  return 5'd16;
    endcase
  endfunction

  // A prohibited mode, or a downward step of a block transfer.
  function automatic logic setting_illegal(dst_mode_e m, xfer_size_e sz);
    return (m == DST_BAD) || ((m == DST_DEC) && (sz == SZ_BLK16));
  endfunction

endpackage

// File: rtl/dma_dst_stepper.sv
module dma_dst_stepper
  import dma_dst_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cur_addr,
  input  dst_mode_e     mode,
  input  xfer_size_e    size,
  output logic [DW-1:0] nxt_addr,
  output logic          illegal
);

  logic [DW-1:0] step;
  logic [DW-1:0] stepped;

  always_comb begin
    step    = DW'(step_bytes(size));
    illegal = setting_illegal(mode, size);
    case (mode)
      DST_INC: stepped = cur_addr + step;
      DST_DEC: stepped = cur_addr - step;
      default: stepped = cur_addr;
    endcase
    nxt_addr = illegal ? cur_addr : stepped;
  end

endmodule

// File: rtl/dma_dack_drv.sv
module dma_dack_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic single_addr,
  input  logic rd_cycle,
  input  logic wr_cycle,
  input  logic ack_mode,
  input  logic ack_level,
  output logic dack_o
);

  logic dual_hit;
  logic ack_active;

  assign dual_hit   = ack_mode ? wr_cycle : rd_cycle;
  assign ack_active = sel && (single_addr ? (rd_cycle || wr_cycle) : dual_hit);
  assign dack_o     = ack_active ? ack_level : ~ack_level;

  assert_single_any_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && single_addr && (rd_cycle || wr_cycle)) |-> (dack_o == ack_level));

  assert_unselected_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (dack_o != ack_level));

  assert_dual_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !single_addr && !rd_cycle && !wr_cycle) |-> (dack_o == ~ack_level));

endmodule

// File: rtl/dma_ch_slice.sv
module dma_ch_slice
  import dma_dst_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit HAS_ACK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          addr_we,
  input  logic [DW-1:0] wdata,
  input  logic          xfer_done,
  input  xfer_size_e    size,
  output logic          ack_mode,
  output logic          ack_level,
  output dst_mode_e     dst_mode,
  output logic [DW-1:0] addr,
  output logic          err
);

  logic [DW-1:0] nxt_addr;
  logic          upd_illegal;

  dma_dst_stepper #(.DW(DW)) u_step (
    .cur_addr (addr),
    .mode     (dst_mode),
    .size     (size),
    .nxt_addr (nxt_addr),
    .illegal  (upd_illegal)
  );

  generate
    if (HAS_ACK) begin : g_ack
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ack_mode  <= 1'b0;
          ack_level <= 1'b0;
        end else if (ctrl_we) begin
          ack_mode  <= wdata[CTRL_AM_BIT];
          ack_level <= wdata[CTRL_AL_BIT];
        end
      end
    end else begin : g_noack
      assign ack_mode  = 1'b0;
      assign ack_level = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_mode <= DST_FIXED;
      addr     <= '0;
      err      <= 1'b0;
    end else begin
      err <= 1'b0;
      if (ctrl_we) dst_mode <= dst_mode_e'(wdata[CTRL_DM_LSB +: 2]);
      if (addr_we) begin
        addr <= wdata;
      end else if (xfer_done) begin
        addr <= nxt_addr;
        err  <= upd_illegal;
      end
    end
  end

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (addr == $past(wdata)));

  assert_hold_on_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && upd_illegal && !addr_we) |=> ((addr == $past(addr)) && err));

  assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(xfer_done && upd_illegal));

  assert_idle_addr_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && !addr_we) |=> $stable(addr));

endmodule

// File: rtl/dma_dst_ack_ctrl.sv
module dma_dst_ack_ctrl
  import dma_dst_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int DW     = 32,
  parameter  int ACK_CH = 2,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_addr_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [CHW-1:0] rd_ch,
  input  logic           rd_addr_sel,
  output logic [DW-1:0]  rd_data,
  input  logic [CHW-1:0] xfer_ch,
  input  logic [1:0]     xfer_size,
  input  logic           single_addr,
  input  logic           rd_cycle,
  input  logic           wr_cycle,
  input  logic           xfer_done,
  output logic [DW-1:0]  dst_addr,
  output logic [NCH-1:0] dack,
  output logic           cfg_err
);

  logic            ch_am   [NCH];
  logic            ch_al   [NCH];
  dst_mode_e       ch_dm   [NCH];
  logic [DW-1:0]   ch_addr [NCH];
  logic [NCH-1:0]  ch_err;
  logic [NCH-1:0]  ch_sel;
  logic [DW-1:0]   ctrl_word [NCH];

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic hit_cfg;
      assign hit_cfg   = cfg_we && (cfg_ch == CHW'(c));
      assign ch_sel[c] = (xfer_ch == CHW'(c));

      dma_ch_slice #(.DW(DW), .HAS_ACK(c < ACK_CH)) u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (hit_cfg && !cfg_addr_sel),
        .addr_we   (hit_cfg && cfg_addr_sel),
        .wdata     (cfg_wdata),
        .xfer_done (xfer_done && ch_sel[c]),
        .size      (xfer_size_e'(xfer_size)),
        .ack_mode  (ch_am[c]),
        .ack_level (ch_al[c]),
        .dst_mode  (ch_dm[c]),
        .addr      (ch_addr[c]),
        .err       (ch_err[c])
      );

      dma_dack_drv u_dack (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (ch_sel[c]),
        .single_addr (single_addr),
        .rd_cycle    (rd_cycle),
        .wr_cycle    (wr_cycle),
        .ack_mode    (ch_am[c]),
        .ack_level   (ch_al[c]),
        .dack_o      (dack[c])
      );

      always_comb begin
        ctrl_word[c]                    = '0;
        ctrl_word[c][CTRL_AM_BIT]       = ch_am[c];
        ctrl_word[c][CTRL_AL_BIT]       = ch_al[c];
        ctrl_word[c][CTRL_DM_LSB +: 2]  = ch_dm[c];
      end

      if (c >= ACK_CH) begin : g_fixed_ack
        assert_fixed_ack_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
          (cfg_we && (cfg_ch == CHW'(c)) && !cfg_addr_sel) |=> (ctrl_word[c][1:0] == 2'b00));
      end
    end
  endgenerate

  assign rd_data  = rd_addr_sel ? ch_addr[rd_ch] : ctrl_word[rd_ch];
  assign dst_addr = ch_addr[xfer_ch];
  assign cfg_err  = |ch_err;

  assert_single_err_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_err));

endmodule

// File: tb/dma_dst_ack_ctrl_bench.sv
module dma_dst_ack_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 readback, 1 dst_addr, 2 dack, 3 err
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic        cfg_addr_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_ch = '0;
  logic        rd_addr_sel = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  xfer_ch = '0;
  logic [1:0]  xfer_size = '0;
  logic        single_addr = 1'b0;
  logic        rd_cycle = 1'b0;
  logic        wr_cycle = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] dst_addr;
  logic [3:0]  dack;
  logic        cfg_err;

  dma_dst_ack_ctrl u_dma_dst_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_addr_sel(cfg_addr_sel), .cfg_wdata(cfg_wdata), .rd_ch(rd_ch),
    .rd_addr_sel(rd_addr_sel), .rd_data(rd_data), .xfer_ch(xfer_ch),
    .xfer_size(xfer_size), .single_addr(single_addr), .rd_cycle(rd_cycle),
    .wr_cycle(wr_cycle), .xfer_done(xfer_done), .dst_addr(dst_addr),
    .dack(dack), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  item_t       q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          ended = 1'b0;

  // Bench model of the programmed state.
  logic [31:0] m_addr [4];
  logic        m_am [4];
  logic        m_al [4];
  logic [1:0]  m_dm [4];

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_dack();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) begin
      bit act;
      if (c != int'(xfer_ch)) act = 1'b0;
      else if (single_addr) act = rd_cycle | wr_cycle;
      else act = m_am[c] ? wr_cycle : rd_cycle;
      v[c] = m_al[c] ? act : !act;
    end
    return v;
  endfunction

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rd_data;
          1: act = dst_addr;
          2: act = {28'b0, dack};
          default: act = {31'b0, cfg_err};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr_reg(int ch, bit asel, logic [31:0] d);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_addr_sel = asel; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    if (asel) m_addr[ch] = d;
    else begin
      if (ch < 2) begin m_am[ch] = d[0]; m_al[ch] = d[1]; end
      m_dm[ch] = d[3:2];
    end
  endtask

  task automatic chk_rd(int ch, bit asel, logic [31:0] exp, string req);
    rd_ch = 2'(ch); rd_addr_sel = asel;
    push(0, exp, req);
    tick();
  endtask

  task automatic xfer(int ch, int sz, string req);
    bit bad;
    logic [31:0] stp;
    xfer_ch = 2'(ch); xfer_size = 2'(sz); xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    bad = (m_dm[ch] == 2'b11) || (m_dm[ch] == 2'b10 && sz == 3);
    stp = (sz == 3) ? 32'd16 : (32'd1 << sz);
    if (!bad) begin
      if (m_dm[ch] == 2'b01) m_addr[ch] = m_addr[ch] + stp;
      else if (m_dm[ch] == 2'b10) m_addr[ch] = m_addr[ch] - stp;
    end
    push(1, m_addr[ch], req);
    push(3, {31'b0, bad}, req);
    tick();
    push(3, 32'd0, {req, " err drops"});
    tick();
  endtask

  task automatic phase(int ch, bit single, bit rd, bit wr, string req);
    xfer_ch = 2'(ch); single_addr = single; rd_cycle = rd; wr_cycle = wr;
    push(2, {28'b0, exp_dack()}, req);
    tick();
    rd_cycle = 1'b0; wr_cycle = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_addr[c] = '0; m_am[c] = 1'b0; m_al[c] = 1'b0; m_dm[c] = 2'b00;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk_rd(0, 0, 32'h0, "R1 ctrl ch0");
    chk_rd(3, 1, 32'h0, "R1 addr ch3");
    push(2, 32'hF, "R1 dack idle");
    push(3, 32'h0, "R1 err");
    tick();

    // R2 control layout, upper bits read zero
    wr_reg(0, 0, 32'hFFFF_FFF7);
    chk_rd(0, 0, 32'h7, "R2 ctrl readback");
    // R11 ack bits ignored on ch2
    wr_reg(2, 0, 32'h0000_000F);
    chk_rd(2, 0, 32'hC, "R11 ch2 ack bits");
    wr_reg(2, 0, 32'h0);

    // R7 address load and readback
    wr_reg(0, 1, 32'h0000_0100);
    chk_rd(0, 1, 32'h100, "R7 addr readback");

    // R3 increment by size
    wr_reg(0, 0, 32'h4);
    for (int s = 0; s < 4; s++) xfer(0, s, "R3 increment");

    // R4 decrement
    wr_reg(0, 0, 32'h8);
    for (int s = 0; s < 3; s++) xfer(0, s, "R4 decrement");

    // R6 illegal settings
    xfer(0, 3, "R6 dec block16");
    wr_reg(0, 0, 32'hC);
    xfer(0, 0, "R6 mode 11");

    // R5 fixed
    wr_reg(0, 0, 32'h0);
    xfer(0, 2, "R5 fixed");

    // R7 write wins over same-cycle completion
    wr_reg(0, 0, 32'h4);
    cfg_we = 1'b1; cfg_ch = 2'd0; cfg_addr_sel = 1'b1; cfg_wdata = 32'hABCD_0000;
    xfer_ch = 2'd0; xfer_size = 2'd2; xfer_done = 1'b1;
    tick();
    cfg_we = 1'b0; xfer_done = 1'b0; m_addr[0] = 32'hABCD_0000;
    push(1, 32'hABCD_0000, "R7 write wins");
    tick();

    // R12 wrap both ways
    wr_reg(0, 1, 32'hFFFF_FFFE);
    xfer(0, 2, "R12 inc wrap");
    chk_rd(0, 1, 32'h0000_0002, "R12 inc wrap value");
    wr_reg(0, 0, 32'h8);
    wr_reg(0, 1, 32'h0000_0001);
    xfer(0, 1, "R12 dec wrap");
    chk_rd(0, 1, 32'hFFFF_FFFF, "R12 dec wrap value");

    // R13 other channels untouched
    wr_reg(1, 1, 32'h0000_0050);
    xfer(0, 0, "R13 ch0 step");
    chk_rd(1, 1, 32'h50, "R13 ch1 untouched");

    // R8 dual timing
    wr_reg(0, 0, 32'h0);
    phase(0, 0, 1, 0, "R8 dual rd am0");
    phase(0, 0, 0, 1, "R8 dual wr am0");
    wr_reg(0, 0, 32'h1);
    phase(0, 0, 0, 1, "R8 dual wr am1");
    phase(0, 0, 1, 0, "R8 dual rd am1");
    // R9 single mode
    phase(0, 1, 1, 0, "R9 single rd");
    phase(0, 1, 0, 1, "R9 single wr");
    // R10 polarity
    wr_reg(1, 0, 32'h2);
    phase(1, 0, 1, 0, "R10 active-high asserted");
    phase(1, 0, 0, 0, "R10 active-high idle");
    phase(0, 0, 0, 1, "R10 other channel inactive");
    // R11 fixed behaviour on ch2 and ch3
    wr_reg(3, 0, 32'h3);
    phase(2, 0, 0, 1, "R11 ch2 wr no ack");
    phase(2, 0, 1, 0, "R11 ch2 rd ack low");
    phase(3, 0, 1, 0, "R11 ch3 rd ack low");

    repeat (2) tick();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule